// File: doc/BRIEF.md
# Core Status Flags Register with Privilege Filtering

This block keeps the status word of one processor core. The word holds two control bits (privileged mode and hardware-interrupt enable) and four condition bits (equal, zero, overflow, sign). The condition bits follow the execution units. An arithmetic result with its overflow indication updates zero, overflow and sign. A register compare updates equal.

Software may write the whole word, as it does when the flags are popped from the stack. The write is filtered by the privilege level in force at that moment. Privileged code can change every bit. Code running in user mode can change only the condition bits, and the control bits keep their values. An interrupt-entry request puts the core into privileged mode and masks hardware interrupts, and it leaves the condition bits as they are.

The block also gates hardware interrupt requests with the enable bit, so a request is only accepted while the enable bit is set.

Top module: `flags_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the flags word becomes 6'b000010: privileged (bit 1) = 1, interrupt enable (bit 0) = 0, and equal (bit 2), zero (bit 3), overflow (bit 4) and sign (bit 5) are all 0.
- R2: An arithmetic update (`alu_upd`) sets zero (bit 3) when `alu_result` is all zeros, sets sign (bit 5) to the MSB of `alu_result`, and sets overflow (bit 4) to `alu_ovf`. It changes no other bit.
- R3: A compare update (`cmp_upd`) sets equal (bit 2) to `cmp_eq` and changes no other bit.
- R4: When an arithmetic update and a compare update occur in the same cycle, both take effect.
- R5: A software write (`sw_wr`) made while privileged (bit 1 = 1) loads all six bits from `sw_data`.
- R6: A software write made in user mode (bit 1 = 0) loads bits 5..2 from `sw_data` and keeps bits 1..0 unchanged.
- R7: An interrupt entry (`int_entry`) sets privileged (bit 1) to 1, clears interrupt enable (bit 0), and keeps bits 5..2.
- R8: Priority within a cycle: interrupt entry first, then software write, then the arithmetic and compare updates. Whatever loses is ignored for that cycle.
- R9: `hw_irq_take` is high exactly when `hw_irq_req` is high and interrupt enable (bit 0) is currently 1.
- R10: With no update, write or entry request, the flags word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_result | input | DATA_W | Result of the arithmetic operation |
| alu_ovf | input | 1 | Overflow indication for the arithmetic operation |
| alu_upd | input | 1 | Update zero, overflow and sign this cycle |
| cmp_eq | input | 1 | The compared registers were equal |
| cmp_upd | input | 1 | Update equal this cycle |
| sw_wr | input | 1 | Software write of the flags word |
| sw_data | input | 6 | Flags value written by software |
| int_entry | input | 1 | Interrupt entry request |
| hw_irq_req | input | 1 | Hardware interrupt request |
| flags_q | output | 6 | Current flags word |
| hw_irq_take | output | 1 | Hardware interrupt accepted |

## Verification
The arithmetic path is driven with a zero result, a result with only the MSB set (together with overflow), a small positive value and an all-ones value. These show whether zero, sign and overflow are each derived independently and whether the equal bit is left alone. Software writes are tried in both privilege levels with patterns that try to flip both control bits. This separates the filtered case from the unfiltered one. Cycles that combine several requests (a write with an arithmetic update, an entry request with a user write, a compare with an arithmetic update) check the priority order and the merging of the two update paths. The interrupt-accept output is checked with the enable bit clear and with it set.

// File: rtl/flags_pkg.sv
package flags_pkg;

    localparam int FLAG_W = 6;

    localparam int BIT_IE   = 0;
    localparam int BIT_PRIV = 1;
    localparam int BIT_EQ   = 2;
    localparam int BIT_ZERO = 3;
    localparam int BIT_OVF  = 4;
    localparam int BIT_SIGN = 5;

    typedef struct packed {
        logic sign;
        logic ovf;
        logic zero;
        logic eq;
        logic priv;
        logic ie;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{sign: 1'b0, ovf: 1'b0, zero: 1'b0,
                                       eq: 1'b0, priv: 1'b1, ie: 1'b0};

    typedef enum logic [1:0] {
        SRC_HOLD  = 2'd0,
        SRC_COND  = 2'd1,
        SRC_SW    = 2'd2,
        SRC_ENTRY = 2'd3
    } next_src_e;

    function automatic flags_t merge_user(flags_t cur, flags_t wr);
        flags_t r;
        r      = wr;
        r.priv = cur.priv;
        r.ie   = cur.ie;
        return r;
    endfunction

endpackage

// File: rtl/flags_cond_gen.sv
module flags_cond_gen
    import flags_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  flags_t              cur,
    input  logic [DATA_W-1:0]   alu_result,
    input  logic                alu_ovf,
    input  logic                alu_upd,
    input  logic                cmp_eq,
    input  logic                cmp_upd,
    output flags_t              cond_next
);
    localparam int MSB = DATA_W - 1;

    always_comb begin
        cond_next = cur;
        if (alu_upd) begin
            cond_next.zero = (alu_result == '0);
            cond_next.sign = alu_result[MSB];
            cond_next.ovf  = alu_ovf;
        end
        if (cmp_upd) begin
            cond_next.eq = cmp_eq;
        end
    end

    // R3
    always_comb begin
        if (!alu_upd) begin
            zso_untouched_chk: assert ({cond_next.zero, cond_next.sign, cond_next.ovf}
                                       == {cur.zero, cur.sign, cur.ovf});
        end
    end
endmodule

// File: rtl/flags_sw_filter.sv
module flags_sw_filter
    import flags_pkg::*;
(
    input  flags_t cur,
    input  flags_t wr_data,
    output flags_t filtered
);
    always_comb begin
        if (cur.priv) begin
            filtered = wr_data;
        end else begin
            filtered = merge_user(cur, wr_data);
        end
    end

    // R6
    always_comb begin
        if (!cur.priv) begin
            user_ctrl_kept_chk: assert (filtered.priv == 1'b0 && filtered.ie == cur.ie);
        end
    end
endmodule

// File: rtl/flags_next_sel.sv
module flags_next_sel
    import flags_pkg::*;
(
    input  flags_t cur,
    input  flags_t cond_next,
    input  flags_t sw_next,
    input  logic   cond_any,
    input  logic   sw_wr,
    input  logic   int_entry,
    output flags_t nxt
);
    next_src_e src;

    always_comb begin
        if (int_entry)      src = SRC_ENTRY;
        else if (sw_wr)     src = SRC_SW;
        else if (cond_any)  src = SRC_COND;
        else                src = SRC_HOLD;
    end

    always_comb begin
        unique case (src)
            SRC_ENTRY: begin
                nxt      = cur;
                nxt.priv = 1'b1;
                nxt.ie   = 1'b0;
            end
            SRC_SW:   nxt = sw_next;
            SRC_COND: nxt = cond_next;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/flags_unit.sv
module flags_unit
    import flags_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              alu_ovf,
    input  logic              alu_upd,
    input  logic              cmp_eq,
    input  logic              cmp_upd,
    input  logic              sw_wr,
    input  logic [5:0]        sw_data,
    input  logic              int_entry,
    input  logic              hw_irq_req,
    output logic [5:0]        flags_q,
    output logic              hw_irq_take
);
    flags_t cur, cond_next, sw_next, nxt;

    flags_cond_gen #(.DATA_W(DATA_W)) u_cond (
        .cur        (cur),
        .alu_result (alu_result),
        .alu_ovf    (alu_ovf),
        .alu_upd    (alu_upd),
        .cmp_eq     (cmp_eq),
        .cmp_upd    (cmp_upd),
        .cond_next  (cond_next)
    );

    flags_sw_filter u_filt (
        .cur      (cur),
        .wr_data  (flags_t'(sw_data)),
        .filtered (sw_next)
    );

    flags_next_sel u_sel (
        .cur       (cur),
        .cond_next (cond_next),
        .sw_next   (sw_next),
        .cond_any  (alu_upd | cmp_upd),
        .sw_wr     (sw_wr),
        .int_entry (int_entry),
        .nxt       (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) cur <= FLAGS_RESET;
        else     cur <= nxt;
    end

    assign flags_q     = cur;
    assign hw_irq_take = hw_irq_req & cur.ie;

    // R1
    reset_value_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> flags_q == 6'b000010);

    // R7
    entry_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        int_entry |=> (flags_q[BIT_PRIV] && !flags_q[BIT_IE]));

    // R7
    entry_cond_kept_chk: assert property (@(posedge clk) disable iff (rst)
        int_entry |=> $stable(flags_q[5:2]));

    // R6
    user_write_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_wr && !int_entry && !flags_q[BIT_PRIV]) |=> $stable(flags_q[1:0]));

    // R2
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (alu_upd && !sw_wr && !int_entry) |=>
            flags_q[BIT_ZERO] == ($past(alu_result) == '0));

    // R2
    eq_untouched_chk: assert property (@(posedge clk) disable iff (rst)
        (!cmp_upd && !sw_wr && !int_entry) |=> $stable(flags_q[BIT_EQ]));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!alu_upd && !cmp_upd && !sw_wr && !int_entry) |=> $stable(flags_q));
endmodule

// File: tb/tb_flags_unit.sv
module tb_flags_unit;
    localparam int DATA_W = 32;
    localparam int NVEC   = 13;
    localparam int VEC_W  = 50;

    logic              clk = 1'b0;
    logic              rst;
    logic [DATA_W-1:0] alu_result;
    logic              alu_ovf, alu_upd, cmp_eq, cmp_upd, sw_wr, int_entry, hw_irq_req;
    logic [5:0]        sw_data;
    logic [5:0]        flags_q;
    logic              hw_irq_take;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    flags_unit #(.DATA_W(DATA_W)) dut (
        .clk(clk), .rst(rst), .alu_result(alu_result), .alu_ovf(alu_ovf),
        .alu_upd(alu_upd), .cmp_eq(cmp_eq), .cmp_upd(cmp_upd), .sw_wr(sw_wr),
        .sw_data(sw_data), .int_entry(int_entry), .hw_irq_req(hw_irq_req),
        .flags_q(flags_q), .hw_irq_take(hw_irq_take)
    );

    // {result, ovf, alu_upd, cmp_eq, cmp_upd, sw_wr, sw_data, int_entry, expected}
    localparam logic [VEC_W-1:0] VECS [NVEC] = '{
        {32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'h00, 1'b0, 6'h0A}, // R2 zero
        {32'h8000_0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'h00, 1'b0, 6'h32}, // R2 sign+ovf
        {32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 6'h00, 1'b0, 6'h36}, // R3 equal
        {32'h0000_0005, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 6'h00, 1'b0, 6'h02}, // R4 both
        {32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 6'h3D, 1'b0, 6'h3D}, // R5 priv write
        {32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 6'h02, 1'b0, 6'h01}, // R6 user write
        {32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 6'h24, 1'b0, 6'h25}, // R6 user write
        {32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'h00, 1'b0, 6'h21}, // R3 clear eq
        {32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h00, 1'b1, 6'h22}, // R7 entry
        {32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 6'h11, 1'b0, 6'h11}, // R8 write beats alu
        {32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 6'h3F, 1'b1, 6'h12}, // R8 entry beats write
        {32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h00, 1'b0, 6'h12}, // R10 hold
        {32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'h00, 1'b0, 6'h22}  // R2 all ones
    };

    localparam string TAGS [NVEC] = '{"R2", "R2", "R3", "R4", "R5", "R6", "R6",
                                      "R3", "R7", "R8", "R8", "R10", "R2"};

    task automatic idle_inputs();
        alu_result = '0; alu_ovf = 0; alu_upd = 0; cmp_eq = 0; cmp_upd = 0;
        sw_wr = 0; sw_data = '0; int_entry = 0; hw_irq_req = 0;
    endtask

    task automatic check(string tag, logic [6:0] act, logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        check("R1", {1'b0, flags_q}, {1'b0, 6'h02});

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            {alu_result, alu_ovf, alu_upd, cmp_eq, cmp_upd, sw_wr, sw_data, int_entry}
                = VECS[i][VEC_W-1:6];
            step();
            check(TAGS[i], {1'b0, flags_q}, {1'b0, VECS[i][5:0]});
        end

        // R9: enable is clear (flags 0x22), request must not be taken
        @(negedge clk);
        idle_inputs();
        hw_irq_req = 1'b1;
        #1;
        check("R9", {6'h00, hw_irq_take}, 7'd0);

        // R9: privileged write sets enable, request taken
        sw_wr = 1'b1; sw_data = 6'h03;
        step();
        @(negedge clk);
        sw_wr = 1'b0;
        #1;
        check("R9", {6'h00, hw_irq_take}, 7'd1);
        hw_irq_req = 1'b0;
        #1;
        check("R9", {6'h00, hw_irq_take}, 7'd0);

        // R1: reset in the middle of a run
        @(negedge clk);
        sw_wr = 1'b1; sw_data = 6'h3D;
        step();
        @(negedge clk);
        sw_wr = 1'b0;
        rst = 1'b1;
        step();
        @(negedge clk);
        rst = 1'b0;
        check("R1", {1'b0, flags_q}, {1'b0, 6'h02});

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule